// File: doc/BRIEF.md
# ACK wait timeout monitor

This block times the wait for an acknowledgement after a frame has gone out on air. The transmit controller pulses a wait request when transmission ends. The block then watches three receiver signals: a PHY-header-detected strobe, a decode-done strobe and an FCS-valid flag. It returns a one-cycle pass pulse or a one-cycle fail pulse.

The wait has two timed stages. The first stage runs from the request until a header is detected. The second stage runs from that header until decoding completes. Two 32-bit configuration words hold the limits for these stages, one word for the 2.4 GHz band and one for the 5 GHz band. A band input picks between them. Limits are counted in units of 0.1 us. A parameter sets the number of clock cycles per unit, 10 at 100 MHz. One bit of each word decides whether a received ACK must also carry a valid FCS.

Top module: `ack_wait_mon`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it is released, `busy_o`, `pass_o` and `fail_o` are all low.
- R2: A cycle with `wait_start_i` high makes `busy_o` high in the next cycle.
- R3: Bits 30:16 of the selected word give the header limit T. Count cycle 0 as the first busy cycle. If no `hdr_det_i` is sampled in cycles 0 to 10*T, `fail_o` pulses in cycle 10*T+1.
- R4: Bits 14:0 give the decode limit D. It is counted from the cycle after the header is accepted, and that cycle is decode cycle 0. If no `dec_done_i` is sampled in decode cycles 0 to 10*D, `fail_o` pulses in decode cycle 10*D+1.
- R5: Suppose `dec_done_i` is sampled in decode cycle k, with k no greater than 10*D. The result appears in decode cycle k+1. If bit 31 is 1, the result is a pass only when `fcs_ok_i` is high in the same cycle as `dec_done_i`, and otherwise a fail. If bit 31 is 0, the result is a pass whatever `fcs_ok_i` is.
- R6: `band_5g_i` is sampled together with the wait request. A value of 0 selects `cfg_2g4_i` and a value of 1 selects `cfg_5g_i`. Changes to `band_5g_i` during a wait have no effect.
- R7: `pass_o` and `fail_o` are never high together. Each stays high for exactly one cycle. In the following cycle `busy_o`, `pass_o` and `fail_o` are all low, unless a new request was given.
- R8: A wait request during a wait restarts the wait: the header stage and all timing begin again from the new request.
- R9: A header or decode-done event sampled in the last allowed cycle of its stage (cycle 10*T or decode cycle 10*D) takes priority over the timeout.
- R10: `dec_done_i` sampled while waiting for the header, and `hdr_det_i` or `dec_done_i` sampled while idle, produce no result and do not shorten or extend the header timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wait_start_i | input | 1 | Starts (or restarts) the ACK wait; one-cycle pulse at end of transmission |
| band_5g_i | input | 1 | Band select sampled at start: 0 = 2.4 GHz word, 1 = 5 GHz word |
| cfg_2g4_i | input | 32 | 2.4 GHz timing word: [31] FCS required, [30:16] header limit, [14:0] decode limit |
| cfg_5g_i | input | 32 | 5 GHz timing word, same layout |
| hdr_det_i | input | 1 | Receiver PHY header detected strobe |
| dec_done_i | input | 1 | Receiver decode complete strobe |
| fcs_ok_i | input | 1 | FCS valid flag, qualified by dec_done_i |
| busy_o | output | 1 | Wait in progress (header or decode stage) |
| pass_o | output | 1 | One-cycle ACK received pulse |
| fail_o | output | 1 | One-cycle ACK missing pulse |

## Verification
Some rules are checked by assertions on every cycle. These cover: pass and fail never high together and each lasting one cycle; busy following a request; a fail following a counter that has reached its stage limit with no event in that cycle; and a fail following a decode that ends without a valid FCS when FCS is required. The unit prescaler is also checked to stay within its range. Other behaviour can only be shown by the bench's sweeps. These cover the exact cycle of every result as a function of the header and decode limits, the latching of the band at start, priority at the limit edge, the restart on a second request, and the default timing word. The sweeps place the header at every cycle of the window and the decode at the window edges, in both bands, with the FCS flag both ways.

// File: rtl/ackw_pkg.sv
package ackw_pkg;
  localparam int LIM_W = 15;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_HDR,
    ST_WAIT_DEC,
    ST_PASS,
    ST_FAIL
  } ackw_state_e;

  // register word layout: decoded by software-visible config
  typedef struct packed {
    logic             need_fcs;
    logic [LIM_W-1:0] hdr_lim;
    logic             pad;
    logic [LIM_W-1:0] dec_lim;
  } ackw_cfg_t;

  localparam logic [31:0] ACKW_CFG_RESET = {1'b1, 15'(55*10+15), 1'b0, 15'd10};
endpackage

// File: rtl/ackw_prescale.sv
module ackw_prescale #(
  parameter int DIV = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && !clr_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i || !en_i || tick_o) cnt_q <= '0;
    else                             cnt_q <= cnt_q + 1'b1;
  end

  // R3
  pre_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/ackw_unit_cnt.sv
module ackw_unit_cnt #(
  parameter int W = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] lim_i,
  output logic         hit_o
);
  logic [W-1:0] cnt_q;

  assign hit_o = (cnt_q == lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (clr_i)                      cnt_q <= '0;
    else if (inc_i && (cnt_q != '1))     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ack_wait_mon.sv
module ack_wait_mon
  import ackw_pkg::*;
#(
  parameter int TICKS_PER_UNIT = 10
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wait_start_i,
  input  logic        band_5g_i,
  input  logic [31:0] cfg_2g4_i,
  input  logic [31:0] cfg_5g_i,
  input  logic        hdr_det_i,
  input  logic        dec_done_i,
  input  logic        fcs_ok_i,
  output logic        busy_o,
  output logic        pass_o,
  output logic        fail_o
);
  ackw_state_e state_q, state_d;
  ackw_cfg_t   cfg_sel;
  logic             need_fcs_q;
  logic [LIM_W-1:0] hdr_lim_q, dec_lim_q, lim;
  logic             clr, tick, hit, unused_pad;

  assign cfg_sel    = ackw_cfg_t'(band_5g_i ? cfg_5g_i : cfg_2g4_i);
  assign unused_pad = cfg_sel.pad;

  // band and limits captured with the request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      need_fcs_q <= 1'b0;
      hdr_lim_q  <= '0;
      dec_lim_q  <= '0;
    end else if (wait_start_i) begin
      need_fcs_q <= cfg_sel.need_fcs;
      hdr_lim_q  <= cfg_sel.hdr_lim;
      dec_lim_q  <= cfg_sel.dec_lim;
    end
  end

  assign busy_o = (state_q == ST_WAIT_HDR) || (state_q == ST_WAIT_DEC);
  assign pass_o = (state_q == ST_PASS);
  assign fail_o = (state_q == ST_FAIL);
  assign clr    = wait_start_i || ((state_q == ST_WAIT_HDR) && hdr_det_i);
  assign lim    = (state_q == ST_WAIT_HDR) ? hdr_lim_q : dec_lim_q;

  ackw_prescale #(.DIV(TICKS_PER_UNIT)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .en_i   (busy_o),
    .tick_o (tick)
  );

  ackw_unit_cnt #(.W(LIM_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .inc_i  (tick),
    .lim_i  (lim),
    .hit_o  (hit)
  );

  always_comb begin
    state_d = state_q;
    if (wait_start_i) state_d = ST_WAIT_HDR;
    else begin
      unique case (state_q)
        ST_WAIT_HDR: begin
          if (hdr_det_i) state_d = ST_WAIT_DEC;  // event beats timeout
          else if (hit)  state_d = ST_FAIL;
        end
        ST_WAIT_DEC: begin
          if (dec_done_i) state_d = (need_fcs_q && !fcs_ok_i) ? ST_FAIL : ST_PASS;
          else if (hit)   state_d = ST_FAIL;
        end
        ST_PASS, ST_FAIL: state_d = ST_IDLE;
        default:          state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // R7
  res_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_o && fail_o));
  // R7
  res_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pass_o || fail_o) |=> !(pass_o || fail_o));
  // R2
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_start_i |=> busy_o);
  // R3
  hdr_timeout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT_HDR && hit && !hdr_det_i && !wait_start_i) |=> fail_o);
  // R5
  fcs_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT_DEC && dec_done_i && need_fcs_q && !fcs_ok_i && !wait_start_i)
      |=> fail_o);
endmodule

// File: tb/sim_ack_wait_mon.sv
module sim_ack_wait_mon;
  import ackw_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int TPU = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wait_start_i = 1'b0, band_5g_i = 1'b0;
  logic [31:0] cfg_2g4_i, cfg_5g_i;
  logic hdr_det_i = 1'b0, dec_done_i = 1'b0, fcs_ok_i = 1'b0;
  logic busy_o, pass_o, fail_o;
  int checks = 0, errors = 0, total_cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ack_wait_mon #(.TICKS_PER_UNIT(TPU)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wait_start_i(wait_start_i), .band_5g_i(band_5g_i),
    .cfg_2g4_i(cfg_2g4_i), .cfg_5g_i(cfg_5g_i), .hdr_det_i(hdr_det_i),
    .dec_done_i(dec_done_i), .fcs_ok_i(fcs_ok_i),
    .busy_o(busy_o), .pass_o(pass_o), .fail_o(fail_o)
  );

  always @(posedge clk) begin
    total_cyc++;
    if (total_cyc > 200000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got %0d cycles, expected at most 200000", total_cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input int got, input int exp, input string what);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic f, input int t, input int d);
    return {f, 15'(t), 1'b0, 15'(d)};
  endfunction

  // res: 1 pass, 2 fail
  task automatic run_case(input logic b, input int hdr_at, input int dec_at, input logic fcs,
                          input int early_dec, input int restart_at, input string tag_in);
    logic [31:0] w;
    int t, d, e, exp_res, exp_cyc, res, c, rs;
    string tag;
    w = b ? cfg_5g_i : cfg_2g4_i;
    t = int'(w[30:16]);
    d = int'(w[14:0]);
    tag = tag_in;
    if (hdr_at < 0 || hdr_at > TPU*t) begin
      exp_res = 2; exp_cyc = TPU*t + 1;
      if (tag == "") tag = "R3";
    end else begin
      e = hdr_at + 1;
      if (dec_at < 0 || dec_at > TPU*d) begin
        exp_res = 2; exp_cyc = e + TPU*d + 1;
        if (tag == "") tag = "R4";
      end else begin
        exp_res = (w[31] && !fcs) ? 2 : 1;
        exp_cyc = e + dec_at + 1;
        if (tag == "") tag = (hdr_at == TPU*t || dec_at == TPU*d) ? "R9" : "R5";
      end
    end
    rs = restart_at;
    @(negedge clk); wait_start_i = 1'b1; band_5g_i = b;
    @(negedge clk); wait_start_i = 1'b0; band_5g_i = ~b;  // R6: change ignored
    chk("R2", int'(busy_o), 1, "busy after start");
    c = 0; res = 0;
    while (res == 0 && c < 20000) begin
      if (pass_o) res = 1;
      else if (fail_o) res = 2;
      if (res == 0) begin
        if (c == rs) begin
          wait_start_i = 1'b1; band_5g_i = b; hdr_det_i = 1'b0; dec_done_i = 1'b0;
          @(negedge clk); wait_start_i = 1'b0; band_5g_i = ~b;
          c = 0; rs = -1;
          continue;
        end
        hdr_det_i  = (c == hdr_at);
        dec_done_i = (c == early_dec) || (dec_at >= 0 && hdr_at >= 0 && c == hdr_at + 1 + dec_at);
        fcs_ok_i   = fcs;
        @(negedge clk);
        c++;
      end
    end
    hdr_det_i = 1'b0; dec_done_i = 1'b0;
    chk(tag, res, exp_res, "result kind");
    chk(tag, c, exp_cyc, "result cycle");
    @(negedge clk);
    chk("R7", int'({busy_o, pass_o, fail_o}), 0, "idle after result");
  endtask

  initial begin
    cfg_2g4_i = mk(1'b1, 3, 2);
    cfg_5g_i  = mk(1'b0, 2, 1);
    #(CLK_PERIOD*2 + 1);
    chk("R1", int'({busy_o, pass_o, fail_o}), 0, "outputs in reset");
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", int'({busy_o, pass_o, fail_o}), 0, "outputs after reset");

    // R10: events while idle
    hdr_det_i = 1'b1; dec_done_i = 1'b1; fcs_ok_i = 1'b1;
    @(negedge clk); hdr_det_i = 1'b0; dec_done_i = 1'b0;
    @(negedge clk);
    chk("R10", int'({busy_o, pass_o, fail_o}), 0, "idle events ignored");

    // sweep both bands (R6), header across the window, decode at edges
    for (int b = 0; b < 2; b++) begin
      int tl;
      tl = (b == 0) ? 3 : 2;
      for (int h = -1; h <= TPU*tl + 1; h++) begin
        int dl;
        dl = (b == 0) ? 2 : 1;
        for (int k = 0; k < 5; k++) begin
          int da;
          da = (k == 0) ? -1 : (k == 1) ? 0 : (k == 2) ? 5 : (k == 3) ? TPU*dl : TPU*dl + 1;
          for (int f = 0; f < 2; f++)
            run_case(b[0], h, da, f[0], -1, -1, "");
        end
      end
    end

    // R10: decode-done before header
    run_case(1'b1, -1, -1, 1'b1, 4, -1, "R10");
    run_case(1'b0, -1, -1, 1'b1, 0, -1, "R10");
    // R8: restart during header wait and during decode wait
    run_case(1'b0, -1, -1, 1'b0, -1, 7, "R8");
    run_case(1'b1, 3, -1, 1'b0, -1, 12, "R8");
    // default word
    cfg_2g4_i = ACKW_CFG_RESET;
    run_case(1'b0, -1, -1, 1'b0, -1, -1, "R3");
    run_case(1'b0, 100, 40, 1'b0, -1, -1, "R5");
    run_case(1'b0, 5650, 100, 1'b1, -1, -1, "R9");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule